// File: doc/BRIEF.md
# Automatic Opponent Paddle Controller

This block positions the second paddle of a two-paddle ball game on a 640 by 480 raster. It keeps the paddle's top row in a register and moves it at most once per video frame, on a single-cycle frame tick. A run-time switch picks who steers. With the switch on, the block compares the ball's vertical centre with the paddle's centre and moves the paddle toward the ball. With the switch off, the second player's up and down buttons move the paddle exactly as in ordinary two-player play.

A dead band around equality keeps a computer-steered paddle still when the ball is nearly level with it, so the paddle does not jitter. The fixed step per frame caps the paddle's speed, so a fast ball can beat it. The paddle top saturates so that the whole paddle stays on screen. A combinational flag tells the pixel generator when the current scan position lies inside the paddle rectangle.

Top module: `opponent_paddle`

## Requirements
- R1: After reset the paddle top is (SCREEN_H - PAD_H) / 2, which is 204 with the defaults.
- R2: The paddle top changes only in the cycle after a cycle with frameTick high. Without a tick it holds, whatever the switch, buttons or ball do.
- R3: With autoEn high and a tick, if ballY < centre - DEAD_BAND (centre = padTop + PAD_H/2), the top moves up (decreases) by STEP, subject to R8.
- R4: With autoEn high and a tick, if ballY > centre + DEAD_BAND, the top moves down (increases) by STEP, subject to R8.
- R5: With autoEn high and a tick, if ballY lies within centre ± DEAD_BAND inclusive (±2 by default), the top holds.
- R6: With autoEn low and a tick, btnUp alone moves the top up by STEP and btnDn alone moves it down by STEP. Both pressed or neither pressed holds it.
- R7: With autoEn high, the buttons have no effect. The switch takes effect at the very next tick.
- R8: The top saturates at 0 when moving up and at SCREEN_H - PAD_H (408 by default) when moving down. It never leaves that range.
- R9: padOn is high exactly when PAD_X <= pixX <= PAD_X + PAD_W - 1 and padTop <= pixY <= padTop + PAD_H - 1 (columns 600 to 603 and 72 rows by default). It follows pixX, pixY and padTop with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| autoEn | input | 1 | 1 = ball tracking, 0 = button control |
| frameTick | input | 1 | One-cycle pulse per frame |
| ballY | input | 10 | Vertical centre of the ball |
| btnUp | input | 1 | Manual move-up button |
| btnDn | input | 1 | Manual move-down button |
| pixX | input | 10 | Current scan column |
| pixY | input | 10 | Current scan row |
| padTop | output | 10 | Top row of the paddle |
| padOn | output | 1 | Current pixel lies on the paddle |

## Verification
The bench uses the default parameters: 480 rows, a 72-row paddle, a 4-pixel step and a ±2 dead band. With these values the paddle reaches both clamp limits exactly after 51 and 102 steps, and ball positions three pixels off centre fall just outside the dead band. Random ball heights over the full screen, with random switch, button and tick patterns, cover tracking in both directions, holding, and saturation at both edges. Directed cases probe the dead-band edges and the paddle rectangle's borders.

// File: rtl/paddle_pkg.sv
package paddle_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } moveCmd_t;
endpackage

// File: rtl/paddle_steer.sv
module paddle_steer
  import paddle_pkg::*;
#(
  parameter int COORD_W   = 10,
  parameter int PAD_H     = 72,
  parameter int DEAD_BAND = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               autoEn,
  input  logic               frameTick,
  input  logic [COORD_W-1:0] ballY,
  input  logic               btnUp,
  input  logic               btnDn,
  input  logic [COORD_W-1:0] padTop,
  output moveCmd_t           cmd
);
  localparam logic [COORD_W:0] HALF_H = (COORD_W+1)'(PAD_H / 2);
  localparam logic [COORD_W:0] BAND   = (COORD_W+1)'(DEAD_BAND);

  logic [COORD_W:0] centre, ballExt;
  logic ballAbove, ballBelow;

  always_comb begin
    centre    = {1'b0, padTop} + HALF_H;
    ballExt   = {1'b0, ballY};
    ballAbove = (ballExt + BAND) < centre;
    ballBelow = ballExt > (centre + BAND);
  end

  always_comb begin
    cmd = '0;
    if (frameTick) begin
      if (autoEn) begin
        cmd.stepUp   = ballAbove;
        cmd.stepDown = ballBelow;
      end else begin
        cmd.stepUp   = btnUp & ~btnDn;
        cmd.stepDown = btnDn & ~btnUp;
      end
    end
  end

  // R2
  strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp | cmd.stepDown) |-> frameTick);

  // R6
  single_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.stepUp, cmd.stepDown}));

  // R7
  auto_ignores_btn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoEn && frameTick && ballY == padTop + COORD_W'(PAD_H / 2))
      |-> !(cmd.stepUp | cmd.stepDown));
endmodule

// File: rtl/paddle_track.sv
module paddle_track
  import paddle_pkg::*;
#(
  parameter int COORD_W  = 10,
  parameter int SCREEN_H = 480,
  parameter int PAD_H    = 72,
  parameter int STEP     = 4,
  parameter int PAD_X    = 600,
  parameter int PAD_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  moveCmd_t           cmd,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  output logic [COORD_W-1:0] padTop,
  output logic               padOn
);
  localparam logic [COORD_W-1:0] TOP_MAX   = COORD_W'(SCREEN_H - PAD_H);
  localparam logic [COORD_W-1:0] TOP_START = COORD_W'((SCREEN_H - PAD_H) / 2);
  localparam logic [COORD_W-1:0] STEP_C    = COORD_W'(STEP);
  localparam logic [COORD_W:0]   X_LO      = (COORD_W+1)'(PAD_X);
  localparam logic [COORD_W:0]   X_HI      = (COORD_W+1)'(PAD_X + PAD_W - 1);
  localparam logic [COORD_W:0]   H_LAST    = (COORD_W+1)'(PAD_H - 1);

  logic [COORD_W-1:0] topNext;
  logic [COORD_W:0]   bottomRow;

  always_comb begin
    topNext = padTop;
    if (cmd.stepUp) begin
      topNext = (padTop < STEP_C) ? '0 : padTop - STEP_C;
    end else if (cmd.stepDown) begin
      topNext = (padTop + STEP_C > TOP_MAX) ? TOP_MAX : padTop + STEP_C;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) padTop <= TOP_START;
    else       padTop <= topNext;
  end

  always_comb begin
    bottomRow = {1'b0, padTop} + H_LAST;
    padOn = ({1'b0, pixX} >= X_LO) && ({1'b0, pixX} <= X_HI) &&
            (pixY >= padTop) && ({1'b0, pixY} <= bottomRow);
  end

  // R8
  top_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    padTop <= TOP_MAX);

  // R3
  up_never_rises_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepUp |=> (padTop <= $past(padTop)) && (padTop + STEP_C >= $past(padTop)));

  // R4
  down_never_falls_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepDown |=> (padTop >= $past(padTop)) && (padTop <= $past(padTop) + STEP_C));
endmodule

// File: rtl/opponent_paddle.sv
module opponent_paddle
  import paddle_pkg::*;
#(
  parameter int COORD_W   = 10,
  parameter int SCREEN_H  = 480,
  parameter int PAD_H     = 72,
  parameter int STEP      = 4,
  parameter int DEAD_BAND = 2,
  parameter int PAD_X     = 600,
  parameter int PAD_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               autoEn,
  input  logic               frameTick,
  input  logic [COORD_W-1:0] ballY,
  input  logic               btnUp,
  input  logic               btnDn,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  output logic [COORD_W-1:0] padTop,
  output logic               padOn
);
  moveCmd_t cmd;

  paddle_steer #(
    .COORD_W(COORD_W), .PAD_H(PAD_H), .DEAD_BAND(DEAD_BAND)
  ) u_steer (
    .clk(clk), .rstN(rstN), .autoEn(autoEn), .frameTick(frameTick),
    .ballY(ballY), .btnUp(btnUp), .btnDn(btnDn), .padTop(padTop), .cmd(cmd)
  );

  paddle_track #(
    .COORD_W(COORD_W), .SCREEN_H(SCREEN_H), .PAD_H(PAD_H), .STEP(STEP),
    .PAD_X(PAD_X), .PAD_W(PAD_W)
  ) u_track (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pixX(pixX), .pixY(pixY),
    .padTop(padTop), .padOn(padOn)
  );

  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(padTop));
endmodule

// File: tb/opponent_paddle_bench.sv
`timescale 1ns/1ps
module opponent_paddle_bench;
  localparam int TOP_MAX = 408;
  localparam int HALF    = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoEn = 1'b0, frameTick = 1'b0, btnUp = 1'b0, btnDn = 1'b0;
  logic [9:0] ballY = '0, pixX = '0, pixY = '0;
  logic [9:0] padTop;
  logic padOn;

  int checks = 0;
  int failures = 0;
  int expTop = 204;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  opponent_paddle u_opponent_paddle (
    .clk(clk), .rstN(rstN), .autoEn(autoEn), .frameTick(frameTick),
    .ballY(ballY), .btnUp(btnUp), .btnDn(btnDn), .pixX(pixX), .pixY(pixY),
    .padTop(padTop), .padOn(padOn)
  );

  function automatic int nextTop(int top, bit a, int ball, bit up, bit dn, bit tick);
    int dir = 0;
    int c = top + HALF;
    if (!tick) return top;
    if (a) begin
      if (ball < c - 2) dir = -1;
      else if (ball > c + 2) dir = 1;
    end else begin
      if (up && !dn) dir = -1;
      else if (dn && !up) dir = 1;
    end
    if (dir < 0) return (top < 4) ? 0 : top - 4;
    if (dir > 0) return (top + 4 > TOP_MAX) ? TOP_MAX : top + 4;
    return top;
  endfunction

  function automatic bit expOn(int top, int x, int y);
    return (x >= 600) && (x <= 603) && (y >= top) && (y <= top + 71);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(string req, bit a, int ball, bit up, bit dn, bit tick);
    @(negedge clk);
    autoEn = a; ballY = 10'(ball); btnUp = up; btnDn = dn; frameTick = tick;
    expTop = nextTop(expTop, a, ball, up, dn, tick);
    @(posedge clk);
    #1;
    check(req, int'(padTop), expTop);
  endtask

  task automatic pixCheck(string req, int x, int y);
    pixX = 10'(x); pixY = 10'(y);
    #0.5;
    check(req, int'(padOn), int'(expOn(expTop, x, y)));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24601));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset top", int'(padTop), 204);
    @(negedge clk);
    rstN = 1'b1;
    step("R1 hold after reset", 0, 0, 0, 0, 0);

    // R2: no tick, everything else active
    step("R2 no tick manual", 0, 0, 1, 0, 0);
    step("R2 no tick auto", 1, 0, 0, 0, 0);

    // R6 manual moves and holds
    step("R6 up only", 0, 0, 1, 0, 1);
    step("R6 down only", 0, 0, 0, 1, 1);
    step("R6 both held", 0, 0, 1, 1, 1);
    step("R6 none held", 0, 0, 0, 0, 1);

    // R5 dead band edges (centre = top + 36)
    step("R5 centre", 1, expTop + HALF, 0, 0, 1);
    step("R5 centre-2", 1, expTop + HALF - 2, 0, 0, 1);
    step("R5 centre+2", 1, expTop + HALF + 2, 0, 0, 1);
    // R3 / R4 just outside band
    step("R3 centre-3 moves up", 1, expTop + HALF - 3, 0, 0, 1);
    step("R4 centre+3 moves down", 1, expTop + HALF + 3, 0, 0, 1);
    // R7 buttons ignored in auto, switch acts at once
    step("R7 auto ignores up btn", 1, expTop + HALF, 1, 0, 1);
    step("R7 auto ignores down btn", 1, expTop + HALF, 0, 1, 1);
    step("R7 switch back to manual", 0, expTop + HALF, 0, 1, 1);

    // R8 clamp at top via manual and bottom via auto
    for (int i = 0; i < 60; i++) step("R8 climb to 0", 0, 0, 1, 0, 1);
    check("R8 top clamp", int'(padTop), 0);
    for (int i = 0; i < 110; i++) step("R8 descend to max", 1, 479, 0, 0, 1);
    check("R8 bottom clamp", int'(padTop), TOP_MAX);

    // R9 rectangle borders
    pixCheck("R9 inside", 601, expTop + 10);
    pixCheck("R9 left edge", 600, expTop);
    pixCheck("R9 left outside", 599, expTop);
    pixCheck("R9 right edge", 603, expTop + 71);
    pixCheck("R9 right outside", 604, expTop + 5);
    pixCheck("R9 below bottom", 602, expTop + 72);
    pixCheck("R9 above top", 602, expTop - 1);

    // random mix, R3 R4 R5 R6 R7 R8 R2 R9
    for (int i = 0; i < 4000; i++) begin
      step("R3/R4/R5/R6 random",
           bit'($urandom_range(1, 0)), int'($urandom_range(479, 0)),
           bit'($urandom_range(1, 0)), bit'($urandom_range(1, 0)),
           ($urandom_range(3, 0) != 0));
      if ((i % 8) == 0)
        pixCheck("R9 random", int'($urandom_range(610, 592)),
                 int'($urandom_range(479, 0)));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule